// File: doc/BRIEF.md
# Fractional Oscillator Code Dither Unit

This unit sits between the loop filter of a fully digital phase-locked loop and its digitally controlled oscillator. It lets the loop ask for frequencies that fall between two neighbouring oscillator codes. Without this, the coarse frequency steps force the loop into a limit cycle around the wanted frequency. The tuning word arrives at the reference rate and carries an integer part and a fractional part. The integer part goes straight to the output. The fractional part drives a noise-shaping modulator that runs on a separate, much faster dither clock, typically the oscillator output divided by a small ratio. The modulator's small integer output is added to the integer part, and the sum is clamped to the legal code range.

Each new tuning word, together with its modulator order, crosses from the reference domain into the dither domain through a toggle handshake. It takes effect on a dither-clock edge. At that same edge the modulator state restarts from zero. A first-order mode gives a single carry bit. A second-order mode cascades two accumulators and gives a value from -1 to +2, which pushes quantisation noise further from the carrier.

Top module: `dco_dither_top`

## Requirements
- R1: After the dither-domain reset, `osc_code` is 0 until a tuning word has been transferred.
- R2: `tune_word[INT_W+FRAC_W-1:FRAC_W]` is the integer part and `tune_word[FRAC_W-1:0]` is the fraction. `tune_order` = 0 selects first order and 1 selects second order. Both are captured on a ref-clock edge with `tune_load` high.
- R3: A captured word is reflected at `osc_code` within 8 dither-clock cycles. Successive loads are spaced at least 8 dither cycles apart.
- R4: While the applied fraction is zero, `osc_code` equals the integer part on every dither cycle, in either order.
- R5: In first order, with the integer part below the maximum code, every output is the integer part or the integer part plus one.
- R6: In second order, every output lies between the integer part minus one and the integer part plus two, before clamping.
- R7: When no clamping occurs, the sum of `osc_code` over any 2^FRAC_W consecutive dither cycles equals 2^FRAC_W times the integer part plus the fraction, within ±1.
- R8: With integer part 0 in second order, `osc_code` never goes below 0 and stays within 0 to 2.
- R9: With integer part 2^INT_W-1, `osc_code` stays at 2^INT_W-1 in first order, and within one below it in second order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference-rate clock of the loop filter |
| ref_rst_n | input | 1 | Synchronous active-low reset, reference domain |
| tune_load | input | 1 | One-cycle strobe that captures a new tuning word |
| tune_word | input | INT_W+FRAC_W | Tuning word: integer part above the fraction |
| tune_order | input | 1 | Modulator order: 0 first, 1 second |
| dith_clk | input | 1 | Fast dither clock (oscillator divided down) |
| dith_rst_n | input | 1 | Synchronous active-low reset, dither domain |
| osc_code | output | INT_W | Dithered oscillator control code |

## Verification
The bench targets both ends of the code range. At integer 0 in second order, a design without clamping would wrap the -1 dither value to the top code. At the maximum integer, a missing clamp would wrap to zero. A zero fraction loaded after a nonzero one checks that the modulator restarts: leftover accumulator state would keep producing stray carries. Averaging over 2^FRAC_W cycles in both orders catches a wrong carry, a dropped second-stage difference term or a misplaced fraction field, because each of these shifts the mean. A directed load measures how many dither cycles the crossing takes, which exposes a missing or extra synchronizer stage.

// File: rtl/dd_pkg.sv
// Shared types for the oscillator code dither unit.
package dd_pkg;
    // Modulator order selected with each tuning word.
    typedef enum logic {
        ORD_FIRST  = 1'b0,
        ORD_SECOND = 1'b1
    } dsm_order_e;

    // Width of the signed dither value (covers -1 .. +2).
    localparam int DITH_W = 3;
endpackage

// File: rtl/tw_cdc.sv
// Tuning word crossing from the reference domain to the dither domain.
// The reference side latches the payload and flips a toggle flag. The dither
// side synchronizes the flag through two flops, detects a change with a
// third flop, and loads the payload on that edge.
// Assumes successive loads are spaced further apart than the synchronizer
// latency, so the held payload is stable whenever it is sampled.
module tw_cdc #(
    parameter int W = 19
) (
    input  logic         ref_clk,
    input  logic         ref_rst_n,
    input  logic         ld_i,
    input  logic [W-1:0] word_i,
    input  logic         dith_clk,
    input  logic         dith_rst_n,
    output logic [W-1:0] word_o,
    output logic         new_o
);
    localparam int SYNC_N = 3;

    logic [W-1:0]      hold_q;
    logic              tog_q;
    logic [SYNC_N-1:0] sync_q;
    logic [W-1:0]      word_q;
    logic              edge_w;

    // Reference side: latch the payload and flip the toggle on each load.
    always_ff @(posedge ref_clk) begin
        if (!ref_rst_n) begin
            hold_q <= '0;
            tog_q  <= 1'b0;
        end else if (ld_i) begin
            hold_q <= word_i;
            tog_q  <= ~tog_q;
        end
    end

    // Dither side: shift the toggle through the synchronizer chain.
    always_ff @(posedge dith_clk) begin
        if (!dith_rst_n) sync_q <= '0;
        else             sync_q <= {sync_q[SYNC_N-2:0], tog_q};
    end

    assign edge_w = sync_q[SYNC_N-1] ^ sync_q[SYNC_N-2];

    // Dither side: take the held payload when a toggle change arrives.
    always_ff @(posedge dith_clk) begin
        if (!dith_rst_n)  word_q <= '0;
        else if (edge_w)  word_q <= hold_q;
    end

    assign word_o = word_q;
    assign new_o  = edge_w;

    // A toggle change is seen for exactly one dither cycle (loads are spaced).
    assert_single_apply_R3: assert property (@(posedge dith_clk) disable iff (!dith_rst_n)
        edge_w |=> !edge_w);
endmodule

// File: rtl/dsm_mod.sv
// Fraction modulator. In first order, a single FRAC_W-bit accumulator adds
// the fraction and its carry is the dither bit. In second order, the first
// stage's residue feeds a second accumulator, and the dither value is
// c1 + c2 - c2 delayed (range -1 .. +2).
// Assumes frac_i and order_i change only together with clr_i, which restarts
// all state from zero.
module dsm_mod
    import dd_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  dsm_order_e               order_i,
    input  logic [FRAC_W-1:0]        frac_i,
    output logic signed [DITH_W-1:0] dith_o
);
    logic [FRAC_W-1:0] acc1_q, acc2_q;
    logic              c2_prev_q;
    logic [FRAC_W:0]   sum1, sum2;
    logic              c1, c2;

    // Stage sums and carries for the current cycle.
    always_comb begin
        sum1 = {1'b0, acc1_q} + {1'b0, frac_i};
        c1   = sum1[FRAC_W];
        sum2 = {1'b0, acc2_q} + {1'b0, sum1[FRAC_W-1:0]};
        c2   = sum2[FRAC_W];
    end

    // Dither value for the selected order.
    always_comb begin
        if (order_i == ORD_SECOND)
            dith_o = $signed({2'b00, c1}) + $signed({2'b00, c2}) - $signed({2'b00, c2_prev_q});
        else
            dith_o = $signed({2'b00, c1});
    end

    // Accumulator update; cleared on reset and whenever a new word is applied.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            acc1_q    <= '0;
            acc2_q    <= '0;
            c2_prev_q <= 1'b0;
        end else begin
            acc1_q <= sum1[FRAC_W-1:0];
            if (order_i == ORD_SECOND) begin
                acc2_q    <= sum2[FRAC_W-1:0];
                c2_prev_q <= c2;
            end else begin
                acc2_q    <= '0;
                c2_prev_q <= 1'b0;
            end
        end
    end

    // A zero fraction yields no dither once state has been restarted.
    assert_zero_frac_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && frac_i == '0) |-> dith_o == 0);

    // Second-order output stays within -1 .. +2.
    assert_mash_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (order_i == ORD_SECOND) |-> (dith_o >= -1 && dith_o <= 2));
endmodule

// File: rtl/code_sat.sv
// Adds the signed dither value to the integer part and clamps the result to
// 0 .. 2^INT_W-1. The result is registered on the dither clock.
module code_sat
    import dd_pkg::*;
#(
    parameter int INT_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [INT_W-1:0]         int_i,
    input  logic signed [DITH_W-1:0] dith_i,
    output logic [INT_W-1:0]         code_o
);
    localparam int SUM_W = INT_W + 2;
    localparam logic signed [SUM_W-1:0] TOP = $signed({2'b00, {INT_W{1'b1}}});

    logic signed [SUM_W-1:0] sum;
    logic [INT_W-1:0]        clamped;

    // Sign-extended sum and range clamp.
    always_comb begin
        sum = $signed({2'b00, int_i}) + $signed({{(SUM_W-DITH_W){dith_i[DITH_W-1]}}, dith_i});
        if (sum < 0)        clamped = '0;
        else if (sum > TOP) clamped = '1;
        else                clamped = sum[INT_W-1:0];
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) code_o <= '0;
        else        code_o <= clamped;
    end
endmodule

// File: rtl/dco_dither_top.sv
// Top of the oscillator code dither unit. It takes the tuning word across to
// the dither clock, noise-shapes its fraction, and outputs the clamped sum of
// the integer part and the dither value.
// Assumes tune_load pulses are spaced at least 8 dither cycles apart.
module dco_dither_top
    import dd_pkg::*;
#(
    parameter int INT_W  = 10,
    parameter int FRAC_W = 8
) (
    input  logic                    ref_clk,
    input  logic                    ref_rst_n,
    input  logic                    tune_load,
    input  logic [INT_W+FRAC_W-1:0] tune_word,
    input  logic                    tune_order,
    input  logic                    dith_clk,
    input  logic                    dith_rst_n,
    output logic [INT_W-1:0]        osc_code
);
    localparam int PAY_W = INT_W + FRAC_W + 1;
    localparam logic [INT_W-1:0] CODE_MAX = '1;

    logic [PAY_W-1:0]         pay_q;
    logic                     apply;
    logic [INT_W-1:0]         int_q;
    logic [FRAC_W-1:0]        frac_q;
    dsm_order_e               order_q;
    logic signed [DITH_W-1:0] dith;

    tw_cdc #(.W(PAY_W)) u_cdc (
        .ref_clk    (ref_clk),
        .ref_rst_n  (ref_rst_n),
        .ld_i       (tune_load),
        .word_i     ({tune_order, tune_word}),
        .dith_clk   (dith_clk),
        .dith_rst_n (dith_rst_n),
        .word_o     (pay_q),
        .new_o      (apply)
    );

    // Split the applied payload into its fields.
    always_comb begin
        order_q = dsm_order_e'(pay_q[PAY_W-1]);
        int_q   = pay_q[INT_W+FRAC_W-1:FRAC_W];
        frac_q  = pay_q[FRAC_W-1:0];
    end

    dsm_mod #(.FRAC_W(FRAC_W)) u_dsm (
        .clk     (dith_clk),
        .rst_n   (dith_rst_n),
        .clr_i   (apply),
        .order_i (order_q),
        .frac_i  (frac_q),
        .dith_o  (dith)
    );

    code_sat #(.INT_W(INT_W)) u_sat (
        .clk    (dith_clk),
        .rst_n  (dith_rst_n),
        .int_i  (int_q),
        .dith_i (dith),
        .code_o (osc_code)
    );

    // A zero fraction passes the integer part through unchanged.
    assert_zero_frac_exact_R4: assert property (@(posedge dith_clk) disable iff (!dith_rst_n)
        (frac_q == '0) |=> osc_code == $past(int_q));

    // First order only ever adds zero or one.
    assert_first_order_step_R5: assert property (@(posedge dith_clk) disable iff (!dith_rst_n)
        (order_q == ORD_FIRST && int_q != CODE_MAX)
        |=> (int'(osc_code) == int'($past(int_q)) || int'(osc_code) == int'($past(int_q)) + 1));

    // The top code saturates instead of wrapping.
    assert_top_saturate_R9: assert property (@(posedge dith_clk) disable iff (!dith_rst_n)
        (order_q == ORD_FIRST && int_q == CODE_MAX) |=> osc_code == CODE_MAX);

    // The bottom code never wraps to a high value.
    assert_bottom_clamp_R8: assert property (@(posedge dith_clk) disable iff (!dith_rst_n)
        (int_q == '0) |=> int'(osc_code) <= 2);
endmodule

// File: tb/sim_dco_dither_top.sv
module sim_dco_dither_top;
    localparam int INT_W  = 10;
    localparam int FRAC_W = 8;
    localparam int WIN    = 1 << FRAC_W;
    localparam int MAXC   = (1 << INT_W) - 1;
    localparam int NV     = 9;

    // Vector: {order, integer, fraction} (R2 field layout).
    localparam logic [INT_W+FRAC_W:0] VEC [0:NV-1] = '{
        {1'b0, 10'd100,  8'h00},
        {1'b1, 10'd100,  8'h00},
        {1'b0, 10'd300,  8'h40},
        {1'b1, 10'd300,  8'h40},
        {1'b0, 10'd512,  8'hFF},
        {1'b1, 10'd7,    8'h01},
        {1'b1, 10'd0,    8'h80},
        {1'b0, 10'd1023, 8'h80},
        {1'b1, 10'd1023, 8'h55}
    };

    logic                    ref_clk = 0, dith_clk = 0;
    logic                    ref_rst_n = 0, dith_rst_n = 0;
    logic                    tune_load = 0;
    logic [INT_W+FRAC_W-1:0] tune_word = '0;
    logic                    tune_order = 0;
    logic [INT_W-1:0]        osc_code;

    int checks = 0, fails = 0;
    bit done = 0;

    always #10 dith_clk = ~dith_clk;
    always #80 ref_clk  = ~ref_clk;

    dco_dither_top #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u0 (
        .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .tune_load(tune_load),
        .tune_word(tune_word), .tune_order(tune_order),
        .dith_clk(dith_clk), .dith_rst_n(dith_rst_n), .osc_code(osc_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input logic ord, input int iv, input int fv);
        @(negedge ref_clk);
        tune_order = ord;
        tune_word  = {iv[INT_W-1:0], fv[FRAC_W-1:0]};
        tune_load  = 1;
        @(negedge ref_clk);
        tune_load  = 0;
    endtask

    initial begin
        repeat (200000) @(posedge dith_clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int lat;
        repeat (4) @(negedge ref_clk);
        ref_rst_n = 1; dith_rst_n = 1;
        @(negedge dith_clk);
        // R1: reset value
        check(osc_code == '0, "R1 reset code", osc_code, 0);

        // R2/R3: integer field reaches the output within 8 dither cycles
        load(1'b0, 55, 0);
        lat = 0;
        for (int k = 0; k < 8; k++) begin
            if (osc_code != 10'd55) begin
                @(negedge dith_clk);
                lat++;
            end
        end
        check(osc_code == 10'd55, "R2/R3 transfer latency", osc_code, 55);

        for (int v = 0; v < NV; v++) begin
            int ord, iv, fv, lo, hi, mn, mx, sum, dl, dh, diff;
            string tag;
            ord = int'(VEC[v][INT_W+FRAC_W]);
            iv  = int'(VEC[v][INT_W+FRAC_W-1:FRAC_W]);
            fv  = int'(VEC[v][FRAC_W-1:0]);
            load(ord[0], iv, fv);
            repeat (16) @(negedge dith_clk);
            dl = (fv == 0) ? 0 : (ord != 0 ? -1 : 0);
            dh = (fv == 0) ? 0 : (ord != 0 ? 2 : 1);
            lo = (iv + dl < 0) ? 0 : iv + dl;
            hi = (iv + dh > MAXC) ? MAXC : iv + dh;
            if (fv == 0)         tag = "R4";
            else if (iv == 0)    tag = "R8";
            else if (iv == MAXC) tag = "R9";
            else if (ord == 0)   tag = "R5";
            else                 tag = "R6";
            mn = MAXC + 1; mx = -1; sum = 0;
            for (int k = 0; k < WIN; k++) begin
                @(negedge dith_clk);
                if (int'(osc_code) < mn) mn = int'(osc_code);
                if (int'(osc_code) > mx) mx = int'(osc_code);
                sum += int'(osc_code);
            end
            check(mn >= lo, {tag, " minimum"}, mn, lo);
            check(mx <= hi, {tag, " maximum"}, mx, hi);
            if (iv >= 1 && iv + 2 <= MAXC) begin
                // R7: window average equals the full tuning value
                diff = sum - (WIN * iv + fv);
                check(diff >= -1 && diff <= 1, "R7 window sum", sum, WIN * iv + fv);
            end
        end

        // R4: zero fraction after a nonzero one, second order, every cycle exact
        load(1'b1, 300, 8'hC3);
        repeat (40) @(negedge dith_clk);
        load(1'b1, 250, 0);
        repeat (16) @(negedge dith_clk);
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 64; k++) begin
                @(negedge dith_clk);
                if (osc_code != 10'd250) bad++;
            end
            check(bad == 0, "R4 restart after nonzero fraction", bad, 0);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule